// File: doc/BRIEF.md
# Recursive Two-Pole Sine Oscillator

This block produces a continuous sampled sinusoid without a waveform table. It stores the two most recent samples. Each advance forms the next sample as the product of a loaded coefficient and the newest sample, minus the older sample. The coefficient equals 2·cos(W), where W = 2π·f_out/f_sample. The recursion has its poles on the unit circle, so the oscillation neither decays nor grows once it is seeded. Each sample costs one multiply and one subtract.

To use the block, the host supplies the coefficient in signed Q2.14 and a seed equal to −A·sin(W) in signed Q1.15, where A is the peak amplitude. The host then pulses the reload input. The reload clears the newest-sample register and loads the seed into the older-sample register. After that, each cycle with the advance input high produces one sample, and the sample is marked by a strobe. The product is rounded before the subtraction, and the result is clamped to the 16-bit signed range. If the loop gain creeps above unity, the output pins at full scale instead of wrapping, and a sticky flag records that the clamp was used.

Top module: `sgen_resonator`

## Requirements
- R1: While rst_n is low, and after it is released, sample is 0, sample_vld is 0 and clip_seen is 0 until the first reload or advance.
- R2: A cycle with reload high sets sample to 0, loads seed as the older stored sample, drives sample_vld low and clears clip_seen on the next edge; reload takes priority over advance in the same cycle.
- R3: A cycle with advance high and reload low sets sample to sat(rnd(freq_k·p1 / 2^14) − p2) on the next edge, where p1 is the current sample and p2 the older stored sample, then shifts p1 into the older slot; sample_vld is high in the cycle after every such cycle.
- R4: The product freq_k·p1 is rounded to the nearest integer after division by 2^14, with an exact half rounded toward +∞ (+0.5 → 1, −0.5 → 0).
- R5: A result above 32767 is output as 32767 and a result below −32768 as −32768; the value never wraps.
- R6: clip_seen goes high on the edge that stores a clamped result, and it stays high through further advances and idle cycles until a reload or reset.
- R7: A cycle with advance and reload both low leaves sample and the stored state unchanged and drives sample_vld low.
- R8: With freq_k = 23170 and seed = −14142, the first 1000 samples stay within 256 LSB of a double-precision evaluation of the same recursion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 1 | Restart: clear newest sample, load seed, clear flag |
| advance | input | 1 | Produce one sample this cycle |
| freq_k | input | 16 | Coefficient 2·cos(W), signed Q2.14 |
| seed | input | 16 | Initial older sample −A·sin(W), signed Q1.15 |
| sample | output | 16 | Current sample, signed Q1.15 |
| sample_vld | output | 1 | High for the cycle after each advance |
| clip_seen | output | 1 | Sticky saturation flag |

## Verification
The recursion is driven with two operating points. The first is a mid-band tone (about fs/8) run for 1000 samples against both a rounding integer model and a double-precision recursion. The second is a low tone (about fs/100), which stresses the coefficient near its upper limit. A coefficient of one LSB with seeds of ±8192 produces exact half-LSB products, which separates round-half-up from truncation and from round-away. A coefficient of −2.0 with a full-scale seed drives both clamp directions, which separates saturation from wrap, and shows whether the flag holds. Further cases cover idle gaps in the middle of a run, reload while advance is high, and resuming after a gap; these reveal lost state and the wrong priority between reload and advance.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
  // Default formats: samples Q1.15, coefficient Q2.14
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned K_W    = 16;
  localparam int unsigned K_FRAC = 14;
endpackage

// File: rtl/sgen_mac.sv
// Combinational step: rnd(k*p1 >> FRAC) - p2, clamped to DW bits.
module sgen_mac #(
  parameter int unsigned DW   = sgen_pkg::SMP_W,
  parameter int unsigned CW   = sgen_pkg::K_W,
  parameter int unsigned FRAC = sgen_pkg::K_FRAC
) (
  input  logic [CW-1:0] k,
  input  logic [DW-1:0] p1,
  input  logic [DW-1:0] p2,
  output logic [DW-1:0] y,
  output logic          sat
);
  localparam int unsigned PW = DW + CW;
  localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [PW:0]   HI   = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0]   LO   = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW:0]   diff;

  always_comb begin
    prod = PW'($signed(k) * $signed(p1));
    rnd  = (prod + HALF) >>> FRAC;
    diff = $signed({rnd[PW-1], rnd}) - $signed({{(PW+1-DW){p2[DW-1]}}, p2});
    sat  = 1'b0;
    y    = diff[DW-1:0];
    if (diff > HI) begin
      y   = HI[DW-1:0];
      sat = 1'b1;
    end else if (diff < LO) begin
      y   = LO[DW-1:0];
      sat = 1'b1;
    end
  end
endmodule

// File: rtl/sgen_taps.sv
// The two delay registers of the recursion.
module sgen_taps #(
  parameter int unsigned DW = sgen_pkg::SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] y_new,
  output logic [DW-1:0] p1,
  output logic [DW-1:0] p2
);
  logic [DW-1:0] p1_nx, p2_nx;
  logic          tap_en;

  always_comb begin
    tap_en = load | adv;
    p1_nx  = p1;
    p2_nx  = p2;
    if (load) begin
      p1_nx = '0;
      p2_nx = seed;
    end else if (adv) begin
      p1_nx = y_new;
      p2_nx = p1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0;
      p2 <= '0;
    end else if (tap_en) begin
      p1 <= p1_nx;
      p2 <= p2_nx;
    end
  end
endmodule

// File: rtl/sgen_resonator.sv
module sgen_resonator #(
  parameter int unsigned DW   = sgen_pkg::SMP_W,
  parameter int unsigned CW   = sgen_pkg::K_W,
  parameter int unsigned FRAC = sgen_pkg::K_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          advance,
  input  logic [CW-1:0] freq_k,
  input  logic [DW-1:0] seed,
  output logic [DW-1:0] sample,
  output logic          sample_vld,
  output logic          clip_seen
);
  logic [DW-1:0] p1, p2, y_step;
  logic          step_sat;
  logic          stepping;
  logic          vld_nx, clip_nx;

  sgen_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
    .k   (freq_k),
    .p1  (p1),
    .p2  (p2),
    .y   (y_step),
    .sat (step_sat)
  );

  sgen_taps #(.DW(DW)) u_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reload),
    .adv   (advance),
    .seed  (seed),
    .y_new (y_step),
    .p1    (p1),
    .p2    (p2)
  );

  always_comb begin
    stepping = advance & ~reload;
    vld_nx   = stepping;
    clip_nx  = clip_seen;
    if (reload)
      clip_nx = 1'b0;
    else if (stepping && step_sat)
      clip_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_vld <= 1'b0;
      clip_seen  <= 1'b0;
    end else begin
      sample_vld <= vld_nx;
      clip_seen  <= clip_nx;
    end
  end

  assign sample = p1;
endmodule

// File: rtl/sgen_resonator_chk.sv
module sgen_resonator_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reload,
  input logic          advance,
  input logic [DW-1:0] sample,
  input logic          sample_vld,
  input logic          clip_seen,
  input logic          step_sat
);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (sample == '0) && !sample_vld && !clip_seen);

  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload) |=> sample_vld);

  assert_clip_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload && step_sat) |=> clip_seen);

  assert_clip_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_seen && !reload) |=> clip_seen);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !reload) |=> $stable(sample) && !sample_vld);
endmodule

bind sgen_resonator sgen_resonator_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reload     (reload),
  .advance    (advance),
  .sample     (sample),
  .sample_vld (sample_vld),
  .clip_seen  (clip_seen),
  .step_sat   (step_sat)
);

// File: tb/sgen_resonator_test.sv
module sgen_resonator_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reload;
  logic        advance;
  logic [15:0] freq_k;
  logic [15:0] seed;
  logic [15:0] sample;
  logic        sample_vld;
  logic        clip_seen;

  int n_chk = 0;
  int n_bad = 0;
  longint m1, m2;
  logic   m_clip;

  always #2 clk = ~clk;

  sgen_resonator uut (
    .clk(clk), .rst_n(rst_n), .reload(reload), .advance(advance),
    .freq_k(freq_k), .seed(seed), .sample(sample),
    .sample_vld(sample_vld), .clip_seen(clip_seen)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference step per R3/R4/R5
  function automatic longint ref_step(input longint k, input longint a, input longint b, output logic s);
    longint r;
    r = ((k * a + 8192) >>> 14) - b;
    s = 1'b0;
    if (r > 32767)  begin r = 32767;  s = 1'b1; end
    if (r < -32768) begin r = -32768; s = 1'b1; end
    return r;
  endfunction

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic do_reload(input logic [15:0] k, input logic [15:0] s, input bit with_adv);
    freq_k = k; seed = s; reload = 1'b1; advance = with_adv;
    @(posedge clk); @(negedge clk);
    reload = 1'b0; advance = 1'b0;
    m1 = 0; m2 = sx(s); m_clip = 1'b0;
    chk(sample == 16'd0, "R2 sample", sx(sample), 0);
    chk(!sample_vld, "R2 vld", sample_vld, 0);
    chk(!clip_seen, "R2 clip", clip_seen, 0);
  endtask

  // advance n cycles, exact check against model each sample
  task automatic run_steps(input int n, input string req);
    logic s;
    longint y;
    for (int i = 0; i < n; i++) begin
      advance = 1'b1;
      @(posedge clk); @(negedge clk);
      y = ref_step(sx(freq_k), m1, m2, s);
      m2 = m1; m1 = y; m_clip = m_clip | s;
      chk(sx(sample) == y, req, sx(sample), y);
      chk(sample_vld, "R3 vld", sample_vld, 1);
      chk(clip_seen == m_clip, "R6 clip", clip_seen, m_clip);
    end
    advance = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; reload = 1'b0; advance = 1'b0; freq_k = '0; seed = '0;
    repeat (3) @(negedge clk);
    chk(sample == 0 && !sample_vld && !clip_seen, "R1 in reset", sample, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample == 0 && !sample_vld && !clip_seen, "R1 after release", sample, 0);
  endtask

  task automatic t_rounding;
    // +0.5 -> 1 (R4)
    do_reload(16'd1, -16'sd8192, 1'b0);
    run_steps(1, "R4 step0");
    chk(sx(sample) == 8192, "R4 seed pass", sx(sample), 8192);
    run_steps(1, "R4 pos half");
    chk(sx(sample) == 1, "R4 +0.5", sx(sample), 1);
    // -0.5 -> 0 (R4)
    do_reload(16'd1, 16'sd8192, 1'b0);
    run_steps(1, "R4 step0 neg");
    run_steps(1, "R4 neg half");
    chk(sx(sample) == 0, "R4 -0.5", sx(sample), 0);
  endtask

  task automatic t_saturate;
    do_reload(16'h8000, 16'h8000, 1'b0);
    run_steps(1, "R5 hi");
    chk(sx(sample) == 32767, "R5 clamp high", sx(sample), 32767);
    chk(clip_seen, "R6 set", clip_seen, 1);
    run_steps(1, "R5 lo");
    chk(sx(sample) == -32768, "R5 clamp low", sx(sample), -32768);
    // sticky through idle and a small-signal run
    repeat (3) @(negedge clk);
    chk(clip_seen, "R6 idle hold", clip_seen, 1);
    do_reload(16'd16384, 16'd0, 1'b0);
    chk(!clip_seen, "R6 cleared by reload", clip_seen, 0);
  endtask

  task automatic t_hold;
    longint held;
    do_reload(16'd32703, -16'sd628, 1'b0);
    run_steps(20, "R3 low tone");
    held = sx(sample);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(sx(sample) == held, "R7 sample held", sx(sample), held);
      chk(!sample_vld, "R7 vld low", sample_vld, 0);
    end
    run_steps(180, "R7 resume / R3 low tone");
  endtask

  task automatic t_priority;
    do_reload(16'd23170, -16'sd14142, 1'b0);
    run_steps(5, "R3 pre");
    do_reload(16'd23170, -16'sd14142, 1'b1); // reload with advance high: R2 priority
    run_steps(1, "R2 priority first sample");
    chk(sx(sample) == 14142, "R2 restart value", sx(sample), 14142);
  endtask

  task automatic t_sine;
    real c, r1, r2, r, err;
    int  over;
    over = 0;
    do_reload(16'd23170, -16'sd14142, 1'b0);
    c = 23170.0 / 16384.0; r1 = 0.0; r2 = -14142.0;
    for (int i = 0; i < 1000; i++) begin
      run_steps(1, "R3 mid tone");
      r = c * r1 - r2; r2 = r1; r1 = r;
      err = real'(sx(sample)) - r;
      if (err < 0.0) err = -err;
      if (err > 256.0) over++;
    end
    chk(over == 0, "R8 samples beyond bound", over, 0);
    chk(!clip_seen, "R8 no clip", clip_seen, 0);
  endtask

  initial begin
    t_reset;
    t_rounding;
    t_saturate;
    t_hold;
    t_priority;
    t_sine;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule